// File: doc/BRIEF.md
# One-Bit Feed-Forward Noise-Shaping Modulator

This block is a fully digital noise-shaping loop. It takes a signed PCM stream that already runs at the oversampled rate and turns it into a stream of single bits, one bit per accepted sample. On each accepted sample the block subtracts the previous output symbol from the input. The previous symbol is fed back as a full-scale value. The difference enters a cascade of saturating integrators. A shifted copy of each integrator output is added into one sum, and the sign of that sum becomes the new output bit. Within each integrator pair a small negative feedback tap forms a resonator, which places a notch in the shaped noise.

The whole update happens in one clock with no pipeline stage, because the bit it produces is needed at once by the next sample. The coefficients are powers of two, so the weighting uses only shifts and adds. When an integrator would run past its numeric range it is clamped instead of wrapping, and a sticky flag records that this happened. The bit stream would normally drive a few-level DAC or be stored as it is. The interpolation filter in front of the block is not part of it.

Top module: `sdm_modulator`

## Requirements
- R1: While `rst` is high at a rising clock edge, all integrators are cleared, `bitOut` becomes 0 and `overflow` becomes 0. Reset takes priority over `sampleValid` in the same cycle.
- R2: At an edge where `sampleValid` is low, the loop state does not change. After that edge `bitOut` and `overflow` are the same as before, and later samples continue as if the idle cycle had not happened.
- R3: The loop error is `sampleIn` minus the feedback value. The feedback value is +2^(DATA_W-1) when the current `bitOut` is 1 and -2^(DATA_W-1) when it is 0, both aligned to the LSB of `sampleIn`.
- R4: Integrator 0 adds the error to its own value. Integrator j>0 adds the value that integrator j-1 held before the edge. When j is odd and j+1<ORDER, integrator j also subtracts the old value of integrator j+1 arithmetically shifted right by RES_SHIFT. This is the resonator.
- R5: The quantizer sum is the sum over j of the newly updated value of integrator j, arithmetically shifted right by j*FF_SHIFT. `bitOut` is registered at the same edge as the integrators. It is 1 when the sum is zero or positive and 0 when the sum is negative.
- R6: An integrator result above 2^(INT_W-1)-1 is clamped to that value. A result below -2^(INT_W-1) is clamped to -2^(INT_W-1). Clamped values are used by the quantizer in the same cycle and by the next stage in the next update.
- R7: `overflow` goes to 1 after the edge of any accepted sample in which at least one integrator was clamped. It then stays at 1 until reset.
- R8: Samples can be accepted on every clock edge, back to back, and each one produces its own output bit one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | The sample on `sampleIn` is taken at this edge |
| sampleIn | input | DATA_W | Signed two's complement input sample |
| bitOut | output | 1 | Output symbol, 1 = positive full scale |
| overflow | output | 1 | Sticky flag: an integrator has saturated |

## Verification
Two things can happen in the same update: an integrator is clamped, and the quantizer decides using that clamped value. The bench provokes this by driving the input at positive and then negative full scale for long runs. This pushes the later integrators against their limits while the output bit is still changing. It also holds reset together with a valid sample, and reset must win. Both cases are judged against a bench model that computes every integrator, every clamp, the quantizer sum and the sticky flag from the requirements. The bench compares `bitOut` and `overflow` against that model after every clock.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic clear;    // wipe all loop state
    logic advance;  // take one sample through the loop
  } sdm_ctrl_t;

endpackage

// File: rtl/sdm_sat_integrator.sv
module sdm_sat_integrator
  import sdm_pkg::*;
#(
  parameter int INT_W = 24
) (
  input  logic                    clk,
  input  sdm_ctrl_t               ctrl,
  input  logic signed [INT_W:0]   addend,
  output logic signed [INT_W-1:0] acc,
  output logic signed [INT_W-1:0] accNext,
  output logic                    clamped
);

  localparam int RAW_W = INT_W + 2;
  localparam logic signed [RAW_W-1:0] MAX_V = {3'b000, {(INT_W-1){1'b1}}};
  localparam logic signed [RAW_W-1:0] MIN_V = {3'b111, {(INT_W-1){1'b0}}};

  logic signed [RAW_W-1:0] raw;

  assign raw = {{2{acc[INT_W-1]}}, acc} + {addend[INT_W], addend};

  always_comb begin
    if (raw > MAX_V) begin
      accNext = {1'b0, {(INT_W-1){1'b1}}};
      clamped = 1'b1;
    end else if (raw < MIN_V) begin
      accNext = {1'b1, {(INT_W-1){1'b0}}};
      clamped = 1'b1;
    end else begin
      accNext = raw[INT_W-1:0];
      clamped = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      acc <= '0;
    end else if (ctrl.advance) begin
      acc <= accNext;
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) ctrl.clear |=> acc == '0);

  // R6
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.advance && !acc[INT_W-1] && !addend[INT_W]) |=> !acc[INT_W-1]);

  // R6
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.advance && acc[INT_W-1] && addend[INT_W]) |=> acc[INT_W-1]);

endmodule

// File: rtl/sdm_loop_datapath.sv
module sdm_loop_datapath
  import sdm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int INT_W     = 24,
  parameter int ORDER     = 5,
  parameter int FF_SHIFT  = 1,
  parameter int RES_SHIFT = 6
) (
  input  logic                     clk,
  input  sdm_ctrl_t                ctrl,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic                     bitOut,
  output logic                     satHit
);

  localparam int SUM_W = INT_W + $clog2(ORDER) + 1;

  logic                     yReg;
  logic signed [DATA_W:0]   fbVal;
  logic signed [DATA_W:0]   err;
  logic signed [INT_W-1:0]  accQ  [ORDER];
  logic signed [INT_W-1:0]  accNx [ORDER];
  logic [ORDER-1:0]         satVec;
  logic signed [SUM_W-1:0]  qSum;
  logic signed [SUM_W-1:0]  tapExt;

  // Full-scale feedback of the current symbol.
  assign fbVal = yReg ? {2'b01, {(DATA_W-1){1'b0}}} : {2'b11, {(DATA_W-1){1'b0}}};
  assign err   = {sampleIn[DATA_W-1], sampleIn} - fbVal;

  for (genvar j = 0; j < ORDER; j++) begin : g_stage
    logic signed [INT_W:0] stageIn;
    if (j == 0) begin : g_first
      assign stageIn = {{(INT_W-DATA_W){err[DATA_W]}}, err};
    end else if ((j % 2 == 1) && (j + 1 < ORDER)) begin : g_res
      logic signed [INT_W-1:0] resTap;
      assign resTap  = accQ[j+1] >>> RES_SHIFT;
      assign stageIn = {accQ[j-1][INT_W-1], accQ[j-1]} - {resTap[INT_W-1], resTap};
    end else begin : g_plain
      assign stageIn = {accQ[j-1][INT_W-1], accQ[j-1]};
    end

    sdm_sat_integrator #(.INT_W(INT_W)) u_int (
      .clk     (clk),
      .ctrl    (ctrl),
      .addend  (stageIn),
      .acc     (accQ[j]),
      .accNext (accNx[j]),
      .clamped (satVec[j])
    );
  end

  // Shift-and-add weighting of the freshly updated integrators.
  always_comb begin
    qSum   = '0;
    tapExt = '0;
    for (int j = 0; j < ORDER; j++) begin
      tapExt = {{(SUM_W-INT_W){accNx[j][INT_W-1]}}, accNx[j]};
      qSum   = qSum + (tapExt >>> (j * FF_SHIFT));
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      yReg <= 1'b0;
    end else if (ctrl.advance) begin
      yReg <= ~qSum[SUM_W-1];
    end
  end

  assign bitOut = yReg;
  assign satHit = |satVec;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.advance |=> $stable(bitOut));

endmodule

// File: rtl/sdm_loop_ctrl.sv
module sdm_loop_ctrl
  import sdm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleValid,
  input  logic      satHit,
  output sdm_ctrl_t ctrl,
  output logic      overflow
);

  assign ctrl.clear   = rst;
  assign ctrl.advance = sampleValid && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
    end else if (ctrl.advance && satHit) begin
      overflow <= 1'b1;
    end
  end

  // R7
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(sampleValid && satHit));

endmodule

// File: rtl/sdm_modulator.sv
module sdm_modulator
  import sdm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int INT_W     = 24,
  parameter int ORDER     = 5,
  parameter int FF_SHIFT  = 1,
  parameter int RES_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              bitOut,
  output logic              overflow
);

  sdm_ctrl_t ctrl;
  logic      satHit;

  sdm_loop_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .satHit      (satHit),
    .ctrl        (ctrl),
    .overflow    (overflow)
  );

  sdm_loop_datapath #(
    .DATA_W    (DATA_W),
    .INT_W     (INT_W),
    .ORDER     (ORDER),
    .FF_SHIFT  (FF_SHIFT),
    .RES_SHIFT (RES_SHIFT)
  ) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .sampleIn (sampleIn),
    .bitOut   (bitOut),
    .satHit   (satHit)
  );

endmodule

// File: tb/test_sdm_modulator.sv
`timescale 1ns/1ps
module test_sdm_modulator;

  localparam int DW  = 16;
  localparam int IW  = 24;
  localparam int ORD = 5;
  localparam int FFS = 1;
  localparam int RSS = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sampleValid = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          bitOut;
  logic          overflow;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  longint mAcc [ORD];
  bit     mY;
  bit     mOvf;

  always #4 clk = ~clk;

  sdm_modulator #(.DATA_W(DW), .INT_W(IW), .ORDER(ORD), .FF_SHIFT(FFS), .RES_SHIFT(RSS))
    i_sdm_modulator (.clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleIn(sampleIn),
                     .bitOut(bitOut), .overflow(overflow));

  function automatic void modelReset();
    for (int j = 0; j < ORD; j++) mAcc[j] = 0;
    mY   = 0;
    mOvf = 0;
  endfunction

  function automatic void modelStep(input int x);
    longint oldA [ORD];
    longint fb, e, inj, n, w;
    longint maxV = (longint'(1) <<< (IW-1)) - 1;
    longint minV = -(longint'(1) <<< (IW-1));
    for (int j = 0; j < ORD; j++) oldA[j] = mAcc[j];
    fb = mY ? (longint'(1) <<< (DW-1)) : -(longint'(1) <<< (DW-1));
    e  = longint'(x) - fb;                            // R3
    w  = 0;
    for (int j = 0; j < ORD; j++) begin
      inj = (j == 0) ? e : oldA[j-1];                 // R4
      if ((j % 2 == 1) && (j + 1 < ORD)) inj = inj - (oldA[j+1] >>> RSS);
      n = oldA[j] + inj;
      if (n > maxV) begin n = maxV; mOvf = 1; end     // R6
      else if (n < minV) begin n = minV; mOvf = 1; end
      mAcc[j] = n;
      w = w + (n >>> (j * FFS));                      // R5
    end
    mY = (w >= 0);
  endfunction

  task automatic check(input string tag);
    total++;
    if (bitOut !== mY) begin
      bad++;
      $display("FAIL %s bitOut actual=%0b expected=%0b", tag, bitOut, mY);
    end
    total++;
    if (overflow !== mOvf) begin
      bad++;
      $display("FAIL %s overflow actual=%0b expected=%0b", tag, overflow, mOvf);
    end
  endtask

  task automatic cyc(input int x, input bit v, input bit r, input string tag);
    sampleIn    = x[DW-1:0];
    sampleValid = v;
    rst         = r;
    @(posedge clk);
    @(negedge clk);
    if (r) modelReset();
    else if (v) modelStep(x);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dummy;
    bit sawOvf;
    dummy = $urandom(32'd1234);
    modelReset();
    @(negedge clk);
    repeat (3) cyc(0, 1'b0, 1'b1, "R1");

    // Zero input, back to back: idle-pattern limit cycle.
    for (int i = 0; i < 60; i++) cyc(0, 1'b1, 1'b0, "R8");

    // Small DC input to exercise error and resonator terms.
    for (int i = 0; i < 200; i++) cyc(1024, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 200; i++) cyc(-2000, 1'b1, 1'b0, "R4");

    // Random gaps: idle cycles must not disturb the loop.
    for (int i = 0; i < 3000; i++) begin
      int x;
      bit v;
      x = int'($urandom_range(0, 16383)) - 8192;
      v = ($urandom_range(0, 9) < 7);
      cyc(x, v, 1'b0, v ? "R5" : "R2");
    end

    // Reset wins over a valid sample in the same cycle.
    cyc(20000, 1'b1, 1'b1, "R1");
    for (int i = 0; i < 20; i++) cyc(3000, 1'b1, 1'b0, "R5");

    // Full-scale runs to drive the integrators into clamping.
    sawOvf = 0;
    for (int i = 0; i < 400; i++) begin
      cyc(32767, 1'b1, 1'b0, "R6");
      if (mOvf) sawOvf = 1;
    end
    for (int i = 0; i < 400; i++) begin
      cyc(-32768, 1'b1, 1'b0, "R6");
      if (mOvf) sawOvf = 1;
    end
    total++;
    if (!sawOvf || overflow !== 1'b1) begin
      bad++;
      $display("FAIL R7 overflow after full scale actual=%0b expected=1", overflow);
    end

    // Flag stays set through idle and quiet input.
    for (int i = 0; i < 50; i++) cyc(0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 300; i++) cyc(int'($urandom_range(0, 255)) - 128, 1'b1, 1'b0, "R7");

    // Reset with valid high clears flag and state.
    cyc(32767, 1'b1, 1'b1, "R1");
    total++;
    if (overflow !== 1'b0 || bitOut !== 1'b0) begin
      bad++;
      $display("FAIL R1 after reset actual=%0b%0b expected=00", overflow, bitOut);
    end
    for (int i = 0; i < 500; i++)
      cyc(int'($urandom_range(0, 65535)) - 32768, 1'b1, 1'b0, "R8");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule